// File: doc/BRIEF.md
# Set-Bit Counting Controller with Embedded Register-File Datapath

This block counts how many bits are set in an 8-bit word. A 3-bit state machine steps a small datapath once per clock: an eight-entry register file with two read ports and one write port, a logic and arithmetic unit, and a shifter. Each state drives one fixed control word into that datapath. The state machine looks at only two conditions: the start request and a flag that is set when the shifted data word is zero.

A request is accepted when `start_i` is high while the controller is idle. On the next clock edge the word on `data_i` is loaded into the data register, R1. The controller then clears the count register, R3, and sets the mask register, R2, to one by incrementing a zero operand. After that it runs a loop of three steps: AND the data with the mask into the temporary register, R4; add R4 to the count; shift the data right by one. The loop repeats while the shifted word is nonzero. In a final one-cycle state the controller reads the count out through the output-enable path and raises `done_o`.

The loop body always runs at least once. The latency therefore depends on the position of the highest set bit of the word, not on how many bits are set.

Top module: `popc_dp_ctrl`

## Requirements
- R1: After an asynchronous reset `done_o` is 0 and `count_o` is 0. The controller stays idle until it samples `start_i` high at a rising edge.
- R2: Only the value on `data_i` at the rising edge one cycle after the edge that accepted start is counted. Values on `data_i` at any other time have no effect on the result.
- R3: The reported count equals the number of 1 bits in the loaded word. A loaded word of 0 reports 0.
- R4: Let c be the cycle in which start is sampled. `done_o` goes high in cycle c+4+3n, where n is the index of the highest set bit plus one, with a minimum of 1 (a zero word gives n=1).
- R5: `done_o` is high for exactly one cycle per accepted request. `start_i` is ignored while a request is in progress, including in the done cycle.
- R6: `count_o` carries the count only while `done_o` is high and is 0 in every other cycle.
- R7: After the done cycle the controller returns to idle for one cycle. If `start_i` is held high, consecutive requests complete every 5+3n cycles.
- R8: Driving `rst_ni` low during a request at once forces `done_o` and `count_o` to 0. A new request after reset is released completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; sampled only while idle |
| data_i | input | DW (8) | Word to count, captured during the load state |
| count_o | output | DW (8) | Number of set bits, valid while done_o is high, 0 otherwise |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A state that is skipped, repeated or mis-decoded shows up at the ports in one of two ways. Either the done pulse arrives early or late against the 4+3n schedule, or it arrives with a count that differs from the set-bit count of the captured word. A bad exit test on the zero flag changes the latency by exactly three cycles per extra or missing pass. A wrong control word corrupts the count no later than the very next done pulse. The bench keeps a phase-and-countdown model of the schedule and compares `done_o` and `count_o` on every cycle. A fault is therefore caught in the first cycle in which the pulse or the count differs.

// File: rtl/popc_pkg.sv
package popc_pkg;
  localparam int unsigned AW    = 3;
  localparam int unsigned NREGS = 1 << AW;

  localparam logic [AW-1:0] R_DATA = 3'd1;
  localparam logic [AW-1:0] R_MASK = 3'd2;
  localparam logic [AW-1:0] R_CNT  = 3'd3;
  localparam logic [AW-1:0] R_TMP  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_CLR   = 3'd2,
    S_MASK  = 3'd3,
    S_AND   = 3'd4,
    S_ACC   = 3'd5,
    S_SHIFT = 3'd6,
    S_DONE  = 3'd7
  } state_e;

  typedef enum logic [2:0] {
    ALU_NOT_A = 3'd0,
    ALU_AND   = 3'd1,
    ALU_XOR   = 3'd2,
    ALU_OR    = 3'd3,
    ALU_DEC   = 3'd4,
    ALU_ADD   = 3'd5,
    ALU_SUB   = 3'd6,
    ALU_INC   = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_PASS  = 3'd0,
    SH_PASS1 = 3'd1,
    SH_RSV2  = 3'd2,
    SH_RSV3  = 3'd3,
    SH_SHL   = 3'd4,
    SH_ROL   = 3'd5,
    SH_SHR   = 3'd6,
    SH_ROR   = 3'd7
  } sh_op_e;

  typedef struct packed {
    logic          in_sel;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_a_en;
    logic [AW-1:0] rd_a_addr;
    logic          rd_b_en;
    logic [AW-1:0] rd_b_addr;
    alu_op_e       alu_op;
    sh_op_e        sh_op;
    logic          out_en;
  } ctrl_word_t;
endpackage

// File: rtl/popc_regfile.sv
module popc_regfile
  import popc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          rea_i,
  input  logic [AW-1:0] raa_i,
  input  logic          reb_i,
  input  logic [AW-1:0] rab_i,
  output logic [DW-1:0] rda_o,
  output logic [DW-1:0] rdb_o
);
  logic [DW-1:0] mem_q [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (we_i && wa_i == AW'(i))             mem_q[i] <= wd_i;
    end
  end

  // a disabled read port drives zero onto its bus
  assign rda_o = rea_i ? mem_q[raa_i] : '0;
  assign rdb_o = reb_i ? mem_q[rab_i] : '0;
endmodule

// File: rtl/popc_alu.sv
module popc_alu
  import popc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_NOT_A: y_o = ~a_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_DEC:   y_o = a_i - DW'(1);
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_INC:   y_o = a_i + DW'(1);
      default:   y_o = a_i;
    endcase
  end
endmodule

// File: rtl/popc_shifter.sv
module popc_shifter
  import popc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  sh_op_e        op_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      SH_SHL:  y_o = {d_i[DW-2:0], 1'b0};
      SH_ROL:  y_o = {d_i[DW-2:0], d_i[DW-1]};
      SH_SHR:  y_o = {1'b0, d_i[DW-1:1]};
      SH_ROR:  y_o = {d_i[0], d_i[DW-1:1]};
      default: y_o = d_i;
    endcase
  end
endmodule

// File: rtl/popc_fsm.sv
module popc_fsm
  import popc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       zero_i,
  output state_e     state_o,
  output ctrl_word_t cw_o,
  output logic       done_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      S_IDLE:  state_d = start_i ? S_LOAD : S_IDLE;
      S_SHIFT: state_d = zero_i ? S_DONE : S_AND;
      S_DONE:  state_d = S_IDLE;
      default: state_d = state_e'(state_q + 3'd1);
    endcase
  end

  always_comb begin
    cw_o        = '0;
    cw_o.alu_op = ALU_ADD;
    cw_o.sh_op  = SH_PASS;
    unique case (state_q)
      S_LOAD: begin
        cw_o.in_sel  = 1'b1;
        cw_o.wr_en   = 1'b1;
        cw_o.wr_addr = R_DATA;
      end
      S_CLR: begin
        cw_o.wr_en   = 1'b1;
        cw_o.wr_addr = R_CNT;
      end
      S_MASK: begin
        cw_o.wr_en   = 1'b1;
        cw_o.wr_addr = R_MASK;
        cw_o.alu_op  = ALU_INC;
      end
      S_AND: begin
        cw_o.wr_en     = 1'b1;
        cw_o.wr_addr   = R_TMP;
        cw_o.rd_a_en   = 1'b1;
        cw_o.rd_a_addr = R_DATA;
        cw_o.rd_b_en   = 1'b1;
        cw_o.rd_b_addr = R_MASK;
        cw_o.alu_op    = ALU_AND;
      end
      S_ACC: begin
        cw_o.wr_en     = 1'b1;
        cw_o.wr_addr   = R_CNT;
        cw_o.rd_a_en   = 1'b1;
        cw_o.rd_a_addr = R_CNT;
        cw_o.rd_b_en   = 1'b1;
        cw_o.rd_b_addr = R_TMP;
      end
      S_SHIFT: begin
        cw_o.wr_en     = 1'b1;
        cw_o.wr_addr   = R_DATA;
        cw_o.rd_a_en   = 1'b1;
        cw_o.rd_a_addr = R_DATA;
        cw_o.sh_op     = SH_SHR;
      end
      S_DONE: begin
        cw_o.rd_a_en   = 1'b1;
        cw_o.rd_a_addr = R_CNT;
        cw_o.out_en    = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;
  assign done_o  = (state_q == S_DONE);
endmodule

// File: rtl/popc_dp_ctrl.sv
module popc_dp_ctrl
  import popc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] count_o,
  output logic          done_o
);
  ctrl_word_t    cw;
  state_e        state;
  logic [DW-1:0] bus_a, bus_b, alu_y, res_y, wr_d;
  logic          res_zero;

  popc_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .zero_i  (res_zero),
    .state_o (state),
    .cw_o    (cw),
    .done_o  (done_o)
  );

  popc_regfile #(.DW(DW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cw.wr_en),
    .wa_i   (cw.wr_addr),
    .wd_i   (wr_d),
    .rea_i  (cw.rd_a_en),
    .raa_i  (cw.rd_a_addr),
    .reb_i  (cw.rd_b_en),
    .rab_i  (cw.rd_b_addr),
    .rda_o  (bus_a),
    .rdb_o  (bus_b)
  );

  popc_alu #(.DW(DW)) u_alu (
    .op_i (cw.alu_op),
    .a_i  (bus_a),
    .b_i  (bus_b),
    .y_o  (alu_y)
  );

  popc_shifter #(.DW(DW)) u_sh (
    .op_i (cw.sh_op),
    .d_i  (alu_y),
    .y_o  (res_y)
  );

  assign wr_d     = cw.in_sel ? data_i : res_y;
  // loop exit looks at the shifted word being written back
  assign res_zero = (res_y == '0);
  assign count_o  = cw.out_en ? res_y : '0;
endmodule

// File: rtl/popc_dp_ctrl_chk.sv
module popc_dp_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [2:0]    state_i,
  input logic [DW-1:0] count_o,
  input logic          done_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0 && !start_i) |=> (state_i == 3'd0)); // R1

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0 && start_i) |=> (state_i == 3'd1)); // R1

  AST_FIXED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i >= 3'd1 && state_i <= 3'd5) |=> (state_i == 3'($past(state_i) + 3'd1))); // R4

  AST_SHIFT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd6) |=> (state_i == 3'd4 || state_i == 3'd7)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_i == 3'd0)); // R7

  AST_COUNT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (count_o == '0)); // R6

  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (count_o <= DW'(DW))); // R3
endmodule

bind popc_dp_ctrl popc_dp_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .state_i (state),
  .count_o (count_o),
  .done_o  (done_o)
);

// File: tb/sim_popc_dp_ctrl.sv
module sim_popc_dp_ctrl;
  localparam int DW     = 8;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] count;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  popc_dp_ctrl #(.DW(DW)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .data_i  (data),
    .count_o (count),
    .done_o  (done)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int popcnt(input logic [DW-1:0] w);
    int c = 0;
    for (int i = 0; i < DW; i++) c += int'(w[i]);
    return c;
  endfunction

  function automatic int passes(input logic [DW-1:0] w);
    int n = 1;
    for (int i = 0; i < DW; i++) if (w[i]) n = i + 1;
    return n;
  endfunction

  // behavioural schedule model: 0 idle, 1 load, 2 run, 3 done
  int m_phase = 0;
  int m_left  = 0;
  int m_cnt   = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0;
      m_left  <= 0;
      m_cnt   <= 0;
    end else begin
      case (m_phase)
        0: if (start) m_phase <= 1;
        1: begin
          m_cnt   <= popcnt(data);
          m_left  <= 2 + 3 * passes(data);
          m_phase <= 2;
        end
        2: begin
          m_left <= m_left - 1;
          if (m_left == 1) m_phase <= 3;
        end
        default: m_phase <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic          e_done;
      logic [DW-1:0] e_cnt;
      e_done = (m_phase == 3);
      e_cnt  = e_done ? DW'(m_cnt) : '0;
      n_chk++;
      if (done !== e_done) begin
        n_bad++;
        $display("FAIL R5 done cyc=%0d got=%0b exp=%0b", cyc, done, e_done);
      end
      n_chk++;
      if (count !== e_cnt) begin
        n_bad++;
        $display("FAIL R6 count cyc=%0d got=%0d exp=%0d", cyc, count, e_cnt);
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // one request; data is scrambled outside the load cycle (R2)
  task automatic run_word(input logic [DW-1:0] w);
    int k;
    @(negedge clk);
    start = 1'b1;
    data  = ~w;
    @(negedge clk);
    start = 1'b0;
    data  = w;
    k = 1;
    while (!done && k < 60) begin
      @(negedge clk);
      k++;
      data  = DW'(k * 37) ^ w;
      start = k[0];
    end
    start = 1'b0;
    check($sformatf("R3 count for %02h", w), int'(count), popcnt(w));
    check($sformatf("R4 latency for %02h", w), k, 4 + 3 * passes(w));
    check($sformatf("R2 word used for %02h", w), int'(count), popcnt(w));
  endtask

  initial begin
    int t1;
    int t2;
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset count", int'(count), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      data = DW'(i * 53 + 7);
      check("R1 idle without start", int'(done), 0);
    end

    run_word(8'h00);
    run_word(8'hFF);
    run_word(8'h01);
    run_word(8'h80);
    run_word(8'hA5);
    run_word(8'h5A);
    run_word(8'h10);
    run_word(8'h7E);
    run_word(8'hC3);

    // start held high: back-to-back requests
    @(negedge clk);
    data  = 8'h2D;
    start = 1'b1;
    while (!done) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!done) @(negedge clk);
    t2 = cyc;
    check("R7 back-to-back period", t2 - t1, 5 + 3 * passes(8'h2D));
    @(negedge clk);
    check("R5 single done pulse", int'(done), 0);
    start = 1'b0;
    repeat (30) @(negedge clk);

    // reset during a request
    start = 1'b1;
    data  = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 done in reset", int'(done), 0);
    check("R8 count in reset", int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_word(8'h03);
    check("R8 recovered count", int'(count), 2);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule